// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block drives an 8-bit asynchronous NAND flash bus from a small word-wide register interface. The host picks a register, then raises a request and holds it until the acknowledge comes back. A write to the command register produces one bus write cycle with the command latch line high. A write to the address register produces one with the address latch line high. Writing the data register produces a plain bus write, and reading it produces a bus read. Only the low byte of the host word reaches the bus, and read data returns zero-extended.

Every bus cycle has three phases: a setup phase, a strobe phase in which the write or read enable is held low, and a hold phase. Each phase length comes from a 4-bit field of one 32-bit timing word. Read cycles and write cycles have separate field groups. Each group also holds a ready-wait field. After a strobe ends, that field hides the device ready pin from the status register for twice its value in clocks, which gives the device time to pull the pin busy. A configuration bit can hold chip enable low across a sequence of cycles, and a control bit gives a soft reset.

Host register select codes: 0 data, 1 address, 2 command, 3 control, 4 configuration, 5 status, 6 timing.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset the bus is idle: chip enable high, both enables high, both latch lines low, data output driver off. The configuration and timing registers read 0.
- R2: A command-register write (select 2) runs one write cycle. The command latch line is high through the whole cycle, the address latch line stays low, and host data bits [7:0] are driven with the output enable on during the strobe.
- R3: An address-register write (select 1) runs one write cycle with the address latch line high and the command latch line low. The command and address latch lines are never high together.
- R4: A data-register write (select 0) runs a write cycle with neither latch line high. A data-register read runs a read cycle that pulses read enable low with the output driver off. The read returns the bus byte captured on the last strobe clock, with bits [31:8] zero.
- R5: A phase field value n gives n+1 clocks, so each phase lasts 1 to 16 clocks. The order is setup (strobe high), then strobe (enable low), then hold (strobe high).
- R6: Read cycles take setup, hold and width from timing bits [3:0], [7:4] and [11:8]. Write, command and address cycles take them from bits [19:16], [23:20] and [27:24].
- R7: When a strobe ends, the ready-wait field n (bits [15:12] for reads, [31:28] for writes) makes status bit 0 read 0 for the next 2*n clocks.
- R8: Outside that window, status bit 0 (select 5) reads the ready pin as sampled on the previous clock, with 1 meaning ready.
- R9: While configuration bit 5 (select 4) is set, chip enable stays low, also between cycles. When it is clear, chip enable is low only during a bus cycle. The enables are never low while chip enable is high.
- R10: A bus access is acknowledged only in the last clock of its hold phase. Until then the host request is stalled. A register access is acknowledged in the clock it is presented.
- R11: Writing control (select 3) with bit 2 set returns the sequencer to idle and clears the configuration register, so chip enable goes high. It also closes any ready-wait window. The timing register keeps its value.
- R12: Reads of the command or address register return 0, and writes to the status register are accepted. Neither starts a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request, held until acknowledged |
| hst_wr | input | 1 | 1 for a write access, 0 for a read |
| hst_sel | input | 3 | Register select |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Access completes in this clock |
| hst_rdata | output | 32 | Read data, valid with the acknowledge |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dq_out | output | 8 | Bus data driven to the device |
| nand_dq_oe | output | 1 | Bus output driver enable |
| nand_dq_in | input | 8 | Bus data from the device |
| nand_rdy | input | 1 | Device ready pin, 1 = ready |

## Verification
A ready-wait window opened by one bus cycle is still counting after that cycle's acknowledge, when the host's next access, a status read, arrives. The two functions therefore meet in the same clock. The bench provokes this with a data write whose write wait (6 clocks) is longer than its hold phase, and reads status at once with the ready pin high. The read must show 0. A data read whose shorter read wait has just run out must show 1. The bench also makes the read data change on every strobe clock except the last, so a capture taken on any other clock of the strobe returns the decoy byte.

// File: rtl/nss_pkg.sv
package nss_pkg;
   typedef enum logic [2:0] {
      SEL_DATA   = 3'd0,
      SEL_ADDR   = 3'd1,
      SEL_CMD    = 3'd2,
      SEL_CTRL   = 3'd3,
      SEL_CFG    = 3'd4,
      SEL_STAT   = 3'd5,
      SEL_TIMING = 3'd6
   } reg_sel_e;

   typedef enum logic [1:0] {
      CYC_CMD  = 2'd0,
      CYC_ADDR = 2'd1,
      CYC_DWR  = 2'd2,
      CYC_DRD  = 2'd3
   } cyc_kind_e;

   localparam int unsigned CFG_CE_BIT    = 5;
   localparam int unsigned CTRL_SRST_BIT = 2;
   // field slots inside a timing group, and group offsets (in fields)
   localparam int unsigned FLD_SETUP = 0;
   localparam int unsigned FLD_HOLD  = 1;
   localparam int unsigned FLD_WIDTH = 2;
   localparam int unsigned FLD_WAIT  = 3;
   localparam int unsigned GRP_RD    = 0;
   localparam int unsigned GRP_WR    = 4;
endpackage

// File: rtl/nss_regs.sv
module nss_regs
   import nss_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  reg_sel_e         sel,
   input  logic [REG_W-1:0] wdata,
   input  logic             fsm_idle,
   input  logic             fsm_done,
   input  logic [BUS_W-1:0] rd_byte,
   input  logic             stat_rdy,
   output logic             ack,
   output logic [REG_W-1:0] rdata,
   output logic             start,
   output cyc_kind_e        kind,
   output logic             soft_rst,
   output logic             cfg_ce,
   output logic [REG_W-1:0] timing
);
   logic is_bus;
   logic reg_hit;
   logic [REG_W-1:0] cfg_word;

   assign is_bus  = (sel == SEL_DATA) || (wr && (sel == SEL_CMD || sel == SEL_ADDR));
   assign reg_hit = req && fsm_idle && !is_bus;
   assign start   = req && fsm_idle && is_bus;
   assign ack     = fsm_done || reg_hit;
   assign soft_rst = reg_hit && wr && (sel == SEL_CTRL) && wdata[CTRL_SRST_BIT];

   always_comb begin
      case (sel)
         SEL_CMD:  kind = CYC_CMD;
         SEL_ADDR: kind = CYC_ADDR;
         default:  kind = wr ? CYC_DWR : CYC_DRD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ce <= 1'b0;
         timing <= '0;
      end else begin
         if (soft_rst)
            cfg_ce <= 1'b0;
         else if (reg_hit && wr && sel == SEL_CFG)
            cfg_ce <= wdata[CFG_CE_BIT];
         if (reg_hit && wr && sel == SEL_TIMING)
            timing <= wdata;
      end
   end

   always_comb begin
      cfg_word = '0;
      cfg_word[CFG_CE_BIT] = cfg_ce;
      case (sel)
         SEL_DATA:   rdata = {{(REG_W-BUS_W){1'b0}}, rd_byte};
         SEL_CFG:    rdata = cfg_word;
         SEL_STAT:   rdata = {{(REG_W-1){1'b0}}, stat_rdy};
         SEL_TIMING: rdata = timing;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/nss_cycle_fsm.sv
module nss_cycle_fsm
   import nss_pkg::*;
#(
   parameter int unsigned REG_W = 32,
   parameter int unsigned BUS_W = 8,
   parameter int unsigned PH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             start,
   input  cyc_kind_e        kind,
   input  logic [BUS_W-1:0] wr_byte,
   input  logic [REG_W-1:0] timing,
   input  logic [BUS_W-1:0] dq_in,
   output logic             idle,
   output logic             done,
   output logic             strobe_end,
   output logic [PH_W-1:0]  wait_units,
   output logic [BUS_W-1:0] rd_byte,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [BUS_W-1:0] dq_out,
   output logic             dq_oe
);
   typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} state_e;

   state_e           state;
   cyc_kind_e        kind_q;
   logic [PH_W-1:0]  cnt;
   logic [BUS_W-1:0] byte_q;
   int unsigned      grp_q;
   int unsigned      grp_in;

   function automatic logic [PH_W-1:0] fld(input logic [REG_W-1:0] t, input int unsigned idx);
      return t[idx*PH_W +: PH_W];
   endfunction

   assign grp_q  = (kind_q == CYC_DRD) ? GRP_RD : GRP_WR;
   assign grp_in = (kind == CYC_DRD) ? GRP_RD : GRP_WR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind_q  <= CYC_CMD;
         cnt     <= '0;
         byte_q  <= '0;
         rd_byte <= '0;
      end else if (soft_rst) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               kind_q <= kind;
               byte_q <= wr_byte;
               cnt    <= fld(timing, grp_in + FLD_SETUP);
               state  <= ST_SETUP;
            end
            ST_SETUP: if (cnt == '0) begin
               cnt   <= fld(timing, grp_q + FLD_WIDTH);
               state <= ST_STROBE;
            end else cnt <= cnt - 1'b1;
            ST_STROBE: if (cnt == '0) begin
               if (kind_q == CYC_DRD) rd_byte <= dq_in;
               cnt   <= fld(timing, grp_q + FLD_HOLD);
               state <= ST_HOLD;
            end else cnt <= cnt - 1'b1;
            ST_HOLD: if (cnt == '0) state <= ST_IDLE;
                     else cnt <= cnt - 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle       = (state == ST_IDLE);
   assign done       = (state == ST_HOLD) && (cnt == '0);
   assign strobe_end = (state == ST_STROBE) && (cnt == '0);
   assign wait_units = fld(timing, grp_q + FLD_WAIT);
   assign cle        = !idle && (kind_q == CYC_CMD);
   assign ale        = !idle && (kind_q == CYC_ADDR);
   assign we_n       = !((state == ST_STROBE) && (kind_q != CYC_DRD));
   assign re_n       = !((state == ST_STROBE) && (kind_q == CYC_DRD));
   assign dq_oe      = !idle && (kind_q != CYC_DRD);
   assign dq_out     = byte_q;

   // R5: the strobe phase runs its full count without skipping
   p_strobe_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STROBE && cnt != '0 && !soft_rst) |=>
      (state == ST_STROBE && cnt == PH_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/nss_rdy_window.sv
module nss_rdy_window #(
   parameter int unsigned PH_W        = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic            load,
   input  logic [PH_W-1:0] wait_units,
   input  logic            rdy_pin,
   output logic            stat_rdy
);
   localparam int unsigned WIN_W = PH_W + 1;

   logic [WIN_W-1:0]       win_cnt;
   logic [SYNC_STAGES-1:0] sync_q;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= rdy_pin;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_pin};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 win_cnt <= '0;
      else if (soft_rst)          win_cnt <= '0;
      else if (load)              win_cnt <= {wait_units, 1'b0};
      else if (win_cnt != '0)     win_cnt <= win_cnt - 1'b1;
   end

   assign stat_rdy = (win_cnt == '0) && sync_q[SYNC_STAGES-1];

   // R7: a nonzero wait hides the pin on the clock after the strobe ends
   p_wait_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !soft_rst && wait_units != '0) |=> !stat_rdy);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nss_pkg::*;
#(
   parameter int unsigned REG_W       = 32,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned PH_W        = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hst_req,
   input  logic             hst_wr,
   input  logic [2:0]       hst_sel,
   input  logic [REG_W-1:0] hst_wdata,
   output logic             hst_ack,
   output logic [REG_W-1:0] hst_rdata,
   output logic             nand_ce_n,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [BUS_W-1:0] nand_dq_out,
   output logic             nand_dq_oe,
   input  logic [BUS_W-1:0] nand_dq_in,
   input  logic             nand_rdy
);
   generate
      if (REG_W < 8*PH_W) begin : g_bad_reg
         $error("REG_W must hold eight timing fields");
      end
      if (BUS_W > REG_W || CFG_CE_BIT >= REG_W) begin : g_bad_bus
         $error("BUS_W and config bits must fit the register word");
      end
   endgenerate

   logic             start, soft_rst, cfg_ce;
   logic             fsm_idle, fsm_done, strobe_end, stat_rdy;
   cyc_kind_e        kind;
   logic [REG_W-1:0] timing;
   logic [BUS_W-1:0] rd_byte;
   logic [PH_W-1:0]  wait_units;

   nss_regs #(.REG_W(REG_W), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .req(hst_req), .wr(hst_wr),
      .sel(reg_sel_e'(hst_sel)), .wdata(hst_wdata),
      .fsm_idle(fsm_idle), .fsm_done(fsm_done), .rd_byte(rd_byte),
      .stat_rdy(stat_rdy), .ack(hst_ack), .rdata(hst_rdata),
      .start(start), .kind(kind), .soft_rst(soft_rst),
      .cfg_ce(cfg_ce), .timing(timing)
   );

   nss_cycle_fsm #(.REG_W(REG_W), .BUS_W(BUS_W), .PH_W(PH_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
      .kind(kind), .wr_byte(hst_wdata[BUS_W-1:0]), .timing(timing),
      .dq_in(nand_dq_in), .idle(fsm_idle), .done(fsm_done),
      .strobe_end(strobe_end), .wait_units(wait_units), .rd_byte(rd_byte),
      .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
      .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
   );

   nss_rdy_window #(.PH_W(PH_W), .SYNC_STAGES(SYNC_STAGES)) u_rdy (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .load(strobe_end),
      .wait_units(wait_units), .rdy_pin(nand_rdy), .stat_rdy(stat_rdy)
   );

   assign nand_ce_n = !(cfg_ce || !fsm_idle);

   p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nand_we_n || nand_re_n);
   p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   p_strobe_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
   p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nand_dq_oe |-> nand_re_n);
   p_soft_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (nand_ce_n && nand_we_n && nand_re_n));
endmodule

// File: tb/nand_strobe_seq_test.sv
module nand_strobe_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_req = 1'b0, hst_wr = 1'b0;
   logic [2:0]  hst_sel = 3'd0;
   logic [31:0] hst_wdata = '0;
   logic        hst_ack;
   logic [31:0] hst_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_out;
   logic [7:0]  nand_dq_in = 8'h5A;
   logic        nand_rdy = 1'b1;

   int n_chk = 0, n_fail = 0;

   localparam logic [2:0] S_DATA = 0, S_ADDR = 1, S_CMD = 2, S_CTRL = 3,
                          S_CFG = 4, S_STAT = 5, S_TIM = 6;
   localparam logic [31:0] TIM_A = 32'h3021_1312;

   always #4 clk = ~clk;

   nand_strobe_seq uut (
      .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_wr(hst_wr),
      .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_ack(hst_ack),
      .hst_rdata(hst_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
      .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
      .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
      .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one host access; starts and ends one step after a rising edge
   task automatic xfer(input logic [2:0] sel, input logic wr, input logic [31:0] wd,
                       input logic [7:0] good, input int rd_last,
                       output logic [31:0] rd, output int pre, output int stb,
                       output int post, output bit f_cle, output bit f_ale,
                       output bit f_oe_bad, output bit f_ce_bad,
                       output logic [7:0] stb_byte);
      bit got = 0;
      logic strobe;
      pre = 0; stb = 0; post = 0; f_cle = 0; f_ale = 0; f_oe_bad = 0; f_ce_bad = 0;
      stb_byte = '0; rd = '0;
      nand_dq_in = 8'h5A;
      hst_sel = sel; hst_wr = wr; hst_wdata = wd; hst_req = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         strobe = !nand_we_n || !nand_re_n;
         if (strobe) begin
            stb++;
            if (nand_ce_n) f_ce_bad = 1;
            if (nand_dq_oe !== wr) f_oe_bad = 1;
            stb_byte = nand_dq_out;
         end else if (stb == 0) pre++;
         else post++;
         if (nand_cle) f_cle = 1;
         if (nand_ale) f_ale = 1;
         nand_dq_in = (!nand_re_n && stb == rd_last) ? good : 8'h5A;
         if (hst_ack) begin
            rd = hst_rdata;
            got = 1;
            break;
         end
      end
      if (!got) chk("R10 access hung", 32'd0, 32'd1);
      @(posedge clk); #1;
      hst_req = 1'b0;
   endtask

   task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
      logic [31:0] r; int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
      xfer(sel, 1'b1, d, 8'h00, 0, r, a, b, c, f1, f2, f3, f4, y);
   endtask

   task automatic reg_rd(input logic [2:0] sel, output logic [31:0] r);
      int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
      xfer(sel, 1'b0, 32'h0, 8'h00, 0, r, a, b, c, f1, f2, f3, f4, y);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // write-type bus cycle with expected phase lengths and latch lines
   task automatic bus_write(input string tag, input logic [2:0] sel, input logic [31:0] wd,
                            input int e_pre, input int e_stb, input int e_post,
                            input bit e_cle, input bit e_ale);
      logic [31:0] r; int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
      xfer(sel, 1'b1, wd, 8'h00, 0, r, a, b, c, f1, f2, f3, f4, y);
      chk({tag, " setup clocks (R5 R6)"}, a, e_pre);
      chk({tag, " strobe clocks (R5 R6)"}, b, e_stb);
      chk({tag, " hold clocks, ack on last (R5 R10)"}, c, e_post);
      chk({tag, " command latch (R2 R3)"}, f1, e_cle);
      chk({tag, " address latch (R2 R3)"}, f2, e_ale);
      chk({tag, " driver on during write (R2)"}, f3, 0);
      chk({tag, " chip enable during strobe (R9)"}, f4, 0);
      chk({tag, " bus byte is low byte (R2)"}, y, wd[7:0]);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 ce_n", nand_ce_n, 1);
      chk("R1 we_n", nand_we_n, 1);
      chk("R1 re_n", nand_re_n, 1);
      chk("R1 cle/ale", {nand_cle, nand_ale}, 0);
      chk("R1 dq_oe", nand_dq_oe, 0);
      @(posedge clk); #1;
      begin
         logic [31:0] r;
         reg_rd(S_CFG, r);  chk("R1 config reads 0", r, 0);
         reg_rd(S_TIM, r);  chk("R1 timing reads 0", r, 0);
      end
   endtask

   task automatic t_min_timing;
      bus_write("R5 all-zero timing cmd", S_CMD, 32'h0000_0011, 2, 1, 1, 1, 0);
   endtask

   task automatic t_cycle_kinds;
      reg_wr(S_TIM, TIM_A);
      bus_write("R2 command", S_CMD, 32'hFFFF_FFA5, 3, 1, 3, 1, 0);
      bus_write("R3 address", S_ADDR, 32'h1234_563C, 3, 1, 3, 0, 1);
      bus_write("R4 data write", S_DATA, 32'h0000_0096, 3, 1, 3, 0, 0);
   endtask

   task automatic t_data_read;
      logic [31:0] r; int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
      xfer(S_DATA, 1'b0, 32'hFFFF_FFFF, 8'hC3, 4, r, a, b, c, f1, f2, f3, f4, y);
      chk("R4 read byte from last strobe clock, zero-extended", r, 32'h0000_00C3);
      chk("R6 read setup clocks", a, 4);
      chk("R6 read strobe clocks", b, 4);
      chk("R6 read hold clocks", c, 2);
      chk("R4 no latch lines on read", {f1, f2}, 0);
      chk("R4 driver off during read", f3, 0);
      chk("R9 ce during read strobe", f4, 0);
   endtask

   task automatic t_max_width;
      reg_wr(S_TIM, 32'h0F00_0000);
      bus_write("R5 16-clock write strobe", S_CMD, 32'h0000_00E7, 2, 16, 1, 1, 0);
      reg_wr(S_TIM, TIM_A);
   endtask

   task automatic t_ready;
      logic [31:0] r;
      nand_rdy = 1'b1;
      reg_wr(S_TIM, TIM_A);
      bus_write("R7 data write for wait", S_DATA, 32'h0000_0001, 3, 1, 3, 0, 0);
      reg_rd(S_STAT, r); chk("R7 write wait still masks ready", r, 0);
      wait_clk(8);
      reg_rd(S_STAT, r); chk("R8 ready after window", r, 1);
      begin
         int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
         xfer(S_DATA, 1'b0, 0, 8'h11, 4, r, a, b, c, f1, f2, f3, f4, y);
      end
      reg_rd(S_STAT, r); chk("R7 short read wait already over", r, 1);
      nand_rdy = 1'b0;
      wait_clk(3);
      reg_rd(S_STAT, r); chk("R8 busy pin reads 0", r, 0);
      nand_rdy = 1'b1;
      wait_clk(3);
      reg_rd(S_STAT, r); chk("R8 ready pin reads 1", r, 1);
   endtask

   task automatic t_force_ce;
      logic [31:0] r;
      reg_wr(S_CFG, 32'h0000_0020);
      @(negedge clk); chk("R9 forced ce low while idle", nand_ce_n, 0);
      @(posedge clk); #1;
      reg_rd(S_CFG, r); chk("R9 config readback", r, 32'h20);
      bus_write("R9 cmd under forced ce", S_CMD, 32'h70, 3, 1, 3, 1, 0);
      @(negedge clk); chk("R9 ce stays low between cycles", nand_ce_n, 0);
      @(posedge clk); #1;
      reg_wr(S_CFG, 32'h0);
      @(negedge clk); chk("R9 ce released", nand_ce_n, 1);
      @(posedge clk); #1;
   endtask

   task automatic t_soft_reset;
      logic [31:0] r;
      reg_wr(S_CFG, 32'h0000_0020);
      reg_wr(S_CTRL, 32'h0000_0004);
      @(negedge clk); chk("R11 ce high after soft reset", nand_ce_n, 1);
      @(posedge clk); #1;
      reg_rd(S_CFG, r); chk("R11 config cleared", r, 0);
      reg_rd(S_TIM, r); chk("R11 timing kept", r, TIM_A);
   endtask

   task automatic t_no_bus;
      logic [31:0] r; int a, b, c; bit f1, f2, f3, f4; logic [7:0] y;
      xfer(S_CMD, 1'b0, 0, 8'h00, 0, r, a, b, c, f1, f2, f3, f4, y);
      chk("R12 command read returns 0", r, 0);
      chk("R12 command read acked at once", a, 1);
      chk("R12 command read no strobe", b, 0);
      xfer(S_STAT, 1'b1, 32'hFFFF_FFFF, 8'h00, 0, r, a, b, c, f1, f2, f3, f4, y);
      chk("R12 status write no strobe", b, 0);
      chk("R12 status write no latch lines", {f1, f2}, 0);
      reg_rd(S_STAT, r); chk("R12 status still follows pin", r, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_min_timing();
      t_cycle_kinds();
      t_data_read();
      t_max_width();
      t_ready();
      t_force_ce();
      t_soft_reset();
      t_no_bus();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule